// File: doc/BRIEF.md
# Tick-Driven Watchdog Timer

This block is a supervisory timer that does not count system clocks. It counts carry events taken from a separate free-running time-base counter. Four levels of that time-base are wired in as tap inputs. A two-bit interval field selects one tap, and each rising edge on the selected tap advances a small watchdog counter. Software starts the timer with one register write. That write carries a kick bit at zero and the interval field. While the timer runs, software must repeat the zero-kick write often enough to keep the counter from reaching its terminal value.

The interval is captured only on the activating write. Later writes can clear the counter but cannot change the interval. If a carry arrives while the counter already holds its maximum, the block raises a one-clock reset request and returns to the stopped state. A system reset also stops the block.

While the device sits in any of its three low-power modes (stop, time-base-only or sleep), the counter is forced to zero and carries are not counted. Counting starts again from zero when the device leaves the mode. Clearing the time-base delays its carries, which stretches the effective timeout.

Top module: `tick_wdog`

## Requirements
- R1: A write with `wr_en`=1 and `wr_kick_n`=0 while the block is stopped sets `wd_active` and captures `wr_sel` as the interval; a write with `wr_kick_n`=1 while stopped has no effect.
- R2: While active, the captured interval is locked: the `wr_sel` value on later writes is ignored until the block stops.
- R3: While active, a write with `wr_kick_n`=0 forces `wd_count` to 0 on the next clock; a write with `wr_kick_n`=1 leaves the count unchanged.
- R4: A carry is a rising edge (0 in the previous clock, 1 now) on `tb_tap[sel]`, where sel is the captured interval; each carry while active and not in low power increments `wd_count` by one.
- R5: The carry that arrives while `wd_count` is 3 (binary 11) makes `wd_reset` high in the following clock, so the timeout is the fourth uncleared carry after activation or clear.
- R6: `wd_reset` is high for exactly one clock, and `wd_active` is low in that same clock with `wd_count` at 0; a new activating write is then accepted with a new interval.
- R7: When a clearing write and a carry occur in the same clock, the clear wins and `wd_count` becomes 0.
- R8: While any of `lp_stop`, `lp_tbonly` or `lp_sleep` is high, `wd_count` is held at 0 and carries are ignored; after the mode input falls, counting restarts from 0.
- R9: With `rst_n` low, `wd_active`, `wd_count` and `wd_reset` are 0, whatever state the block was in.
- R10: While stopped, carries are ignored, `wd_count` stays 0 and `wd_reset` stays low.
- R11: If the time-base restarts from zero, carries resume only at its next rising tap edge, so the reset request comes correspondingly later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control register write strobe |
| wr_kick_n | input | 1 | Kick bit of the write; 0 activates or clears |
| wr_sel | input | SEL_W | Interval select of the write |
| tb_tap | input | 2**SEL_W | Selectable time-base levels, one per interval |
| lp_stop | input | 1 | Device is in stop mode |
| lp_tbonly | input | 1 | Device is in time-base-only mode |
| lp_sleep | input | 1 | Device is in sleep mode |
| wd_active | output | 1 | Watchdog running |
| wd_count | output | CNT_W | Current watchdog count |
| wd_reset | output | 1 | One-clock reset request |

## Verification
The hardest situations to reach are those where two events fall in one clock: a clearing write that lands on the same clock as a carry, and a low-power entry that falls between two carries. The bench drives the time-base value directly, one value per clock. It can therefore put a tap's rising edge on any chosen cycle and align the write or the mode input with it. Each of the four intervals is then run to expiry and timed against the tap period.

// File: rtl/tick_wdog_pkg.sv
package tick_wdog_pkg;
   // Decoded effect of one control write
   typedef struct packed {
      logic activate;
      logic clear;
   } wd_cmd_t;
endpackage

// File: rtl/tick_wdog_tap.sv
module tick_wdog_tap #(
   parameter int SEL_W       = 2,
   parameter bit EDGE_DETECT = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [(1<<SEL_W)-1:0] tb_tap,
   input  logic [SEL_W-1:0]      sel,
   output logic                  carry
);
   localparam int N_TAPS = 1 << SEL_W;

   logic [N_TAPS-1:0] tap_evt;

   generate
      if (EDGE_DETECT) begin : g_edge
         logic [N_TAPS-1:0] tap_prev;
         always_ff @(posedge clk) begin
            if (!rst_n) tap_prev <= '0;
            else        tap_prev <= tb_tap;
         end
         for (genvar gi = 0; gi < N_TAPS; gi++) begin : g_tap
            assign tap_evt[gi] = tb_tap[gi] & ~tap_prev[gi];
         end
      end else begin : g_pulse
         assign tap_evt = tb_tap;
      end
   endgenerate

   assign carry = tap_evt[sel];

   generate
      if (EDGE_DETECT) begin : g_chk
         AST_CARRY_ON_HIGH_TAP: assert property (@(posedge clk) disable iff (!rst_n)
            carry |-> tb_tap[sel]); // R4
      end
   endgenerate
endmodule

// File: rtl/tick_wdog_ctrl.sv
module tick_wdog_ctrl
   import tick_wdog_pkg::*;
#(
   parameter int SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             wr_kick_n,
   input  logic [SEL_W-1:0] wr_sel,
   input  logic             expire,
   output logic             active,
   output logic [SEL_W-1:0] sel_q,
   output wd_cmd_t          cmd
);
   always_comb begin
      cmd.activate = wr_en & ~wr_kick_n & ~active;
      cmd.clear    = wr_en & ~wr_kick_n &  active;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         sel_q  <= '0;
      end else if (cmd.activate) begin
         active <= 1'b1;
         sel_q  <= wr_sel;
      end else if (expire) begin
         active <= 1'b0;
      end
   end

   AST_SEL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (active && $past(active)) |-> $stable(sel_q)); // R2
   AST_KICK_ONE_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && !(wr_en && !wr_kick_n)) |=> !active); // R1
endmodule

// File: rtl/tick_wdog_cnt.sv
module tick_wdog_cnt #(
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             clear,
   input  logic             hold,
   input  logic             carry,
   output logic [CNT_W-1:0] count,
   output logic             expire
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   always_comb expire = active & ~clear & ~hold & carry & (count == CNT_MAX);

   always_ff @(posedge clk) begin
      if (!rst_n)                                count <= '0;
      else if (!active || clear || hold || expire) count <= '0;
      else if (carry)                            count <= count + CNT_W'(1);
   end

   AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (active && clear) |=> (count == '0)); // R7
   AST_LOWPOWER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> (count == '0)); // R8
   AST_STOPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> (count == '0)); // R10
   AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (count != $past(count)) |-> (count == '0 || count == $past(count) + CNT_W'(1))); // R4
endmodule

// File: rtl/tick_wdog.sv
module tick_wdog
   import tick_wdog_pkg::*;
#(
   parameter int SEL_W       = 2,
   parameter int CNT_W       = 2,
   parameter bit EDGE_DETECT = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic                  wr_kick_n,
   input  logic [SEL_W-1:0]      wr_sel,
   input  logic [(1<<SEL_W)-1:0] tb_tap,
   input  logic                  lp_stop,
   input  logic                  lp_tbonly,
   input  logic                  lp_sleep,
   output logic                  wd_active,
   output logic [CNT_W-1:0]      wd_count,
   output logic                  wd_reset
);
   generate
      if (SEL_W < 1 || SEL_W > 4) begin : g_bad_sel
         $error("tick_wdog: SEL_W out of range");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("tick_wdog: CNT_W must be at least 1");
      end
   endgenerate

   logic             carry;
   logic             expire;
   logic             low_power;
   logic [SEL_W-1:0] sel_q;
   wd_cmd_t          cmd;

   assign low_power = lp_stop | lp_tbonly | lp_sleep;

   tick_wdog_ctrl #(.SEL_W(SEL_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_kick_n (wr_kick_n),
      .wr_sel    (wr_sel),
      .expire    (expire),
      .active    (wd_active),
      .sel_q     (sel_q),
      .cmd       (cmd)
   );

   tick_wdog_tap #(.SEL_W(SEL_W), .EDGE_DETECT(EDGE_DETECT)) u_tap (
      .clk    (clk),
      .rst_n  (rst_n),
      .tb_tap (tb_tap),
      .sel    (sel_q),
      .carry  (carry)
   );

   tick_wdog_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (wd_active),
      .clear  (cmd.clear),
      .hold   (low_power),
      .carry  (carry),
      .count  (wd_count),
      .expire (expire)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) wd_reset <= 1'b0;
      else        wd_reset <= expire;
   end

   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      wd_reset |=> !wd_reset); // R6
   AST_RESET_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      wd_reset |-> (!wd_active && wd_count == '0)); // R6
   AST_RESET_AFTER_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wd_reset) |-> ($past(wd_count) == {CNT_W{1'b1}})); // R5
endmodule

// File: tb/tick_wdog_test.sv
module tick_wdog_test;
   localparam int SEL_W = 2;
   localparam int CNT_W = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic       wr_kick_n = 1'b1;
   logic [1:0] wr_sel = '0;
   logic [3:0] tb_tap;
   logic       lp_stop = 1'b0;
   logic       lp_tbonly = 1'b0;
   logic       lp_sleep = 1'b0;
   logic       wd_active;
   logic [1:0] wd_count;
   logic       wd_reset;

   logic [9:0] tbv = '0;
   logic [9:0] prev_tbv = '0;
   int total = 0;
   int bad = 0;
   bit done = 0;
   int m_act = 0;
   int m_sel = 0;
   int m_cnt = 0;

   always #4 clk = ~clk;

   // taps are time-base bits 1, 3, 5, 7
   assign tb_tap = {tbv[7], tbv[5], tbv[3], tbv[1]};

   tick_wdog #(.SEL_W(SEL_W), .CNT_W(CNT_W)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kick_n(wr_kick_n),
      .wr_sel(wr_sel), .tb_tap(tb_tap), .lp_stop(lp_stop), .lp_tbonly(lp_tbonly),
      .lp_sleep(lp_sleep), .wd_active(wd_active), .wd_count(wd_count), .wd_reset(wd_reset)
   );

   task automatic check(string rq, string what, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s got=%0d exp=%0d", rq, what, act, exp);
      end
   endtask

   // one clock with the current inputs; model from the requirements, then compare
   task automatic step(string rq);
      int tp;
      int rise;
      int lp;
      int exp_rst;
      tp = 1 + 2 * m_sel;
      rise = (tbv[tp] && !prev_tbv[tp]) ? 1 : 0;
      lp = (lp_stop || lp_tbonly || lp_sleep) ? 1 : 0;
      exp_rst = 0;
      if (!rst_n) begin
         m_act = 0; m_cnt = 0;
      end else if (m_act == 0) begin
         if (wr_en && !wr_kick_n) begin m_act = 1; m_sel = int'(wr_sel); end
         m_cnt = 0;
      end else if (wr_en && !wr_kick_n) begin
         m_cnt = 0;
      end else if (lp != 0) begin
         m_cnt = 0;
      end else if (rise != 0) begin
         if (m_cnt == 3) begin exp_rst = 1; m_act = 0; m_cnt = 0; end
         else m_cnt++;
      end
      @(posedge clk);
      #1;
      prev_tbv = rst_n ? tbv : '0;
      check(rq, "wd_active", int'(wd_active), m_act);
      check(rq, "wd_count", int'(wd_count), m_cnt);
      check(rq, "wd_reset", int'(wd_reset), exp_rst);
   endtask

   task automatic write(logic kick_n, logic [1:0] sel, string rq);
      wr_en = 1'b1; wr_kick_n = kick_n; wr_sel = sel;
      step(rq);
      wr_en = 1'b0; wr_kick_n = 1'b1;
   endtask

   task automatic sys_reset(string rq);
      rst_n = 1'b0;
      step(rq);
      rst_n = 1'b1;
   endtask

   initial begin
      #(8 * 150000);
      total++; bad++;
      $display("FAIL watchdog expired got=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      // R9: reset state
      step("R9");
      step("R9");
      rst_n = 1'b1;

      // R10: stopped, carries ignored
      for (int k = 1; k <= 40; k++) begin tbv = 10'(k); step("R10"); end

      // R1: kick bit 1 while stopped does not start
      write(1'b1, 2'd0, "R1");
      for (int k = 41; k <= 60; k++) begin tbv = 10'(k); step("R1"); end

      // R5 / R6: every interval to expiry, reactivated after each expiry
      for (int s = 0; s < 4; s++) begin
         tbv = '0;
         write(1'b0, 2'(s), "R1");
         for (int k = 1; k <= (7 << (1 + 2 * s)) + 3; k++) begin
            tbv = 10'(k); step("R5");
         end
         check("R6", "stopped after expiry", int'(wd_active), 0);
      end

      // R2: interval locked after activation
      tbv = '0;
      write(1'b0, 2'd0, "R2");
      tbv = 10'd1;
      write(1'b0, 2'd3, "R2");
      for (int k = 2; k <= 20; k++) begin tbv = 10'(k); step("R2"); end
      check("R2", "expired on first interval", int'(wd_active), 0);

      // R3: periodic clearing, kick bit 1 has no effect
      tbv = '0;
      write(1'b0, 2'd1, "R3");
      for (int k = 1; k <= 120; k++) begin
         tbv = 10'(k);
         if (k == 30 || k == 50) write(1'b0, 2'd2, "R3");
         else if (k == 40) write(1'b1, 2'd0, "R3");
         else step("R3");
      end

      // R7: clear and carry in the same clock (tap 1 rises at 2, 6, 10)
      sys_reset("R9");
      tbv = '0;
      write(1'b0, 2'd0, "R7");
      for (int k = 1; k <= 16; k++) begin
         tbv = 10'(k);
         if (k == 10) write(1'b0, 2'd0, "R7");
         else step("R7");
      end

      // R8: each low-power mode clears and pauses
      for (int m = 0; m < 3; m++) begin
         sys_reset("R9");
         tbv = '0;
         write(1'b0, 2'd0, "R8");
         for (int k = 1; k <= 24; k++) begin
            tbv = 10'(k);
            lp_stop   = (m == 0 && k >= 7 && k <= 12);
            lp_tbonly = (m == 1 && k >= 7 && k <= 12);
            lp_sleep  = (m == 2 && k >= 7 && k <= 12);
            step("R8");
         end
      end
      lp_stop = 1'b0; lp_tbonly = 1'b0; lp_sleep = 1'b0;

      // R11: time-base restart delays the timeout
      sys_reset("R9");
      tbv = '0;
      write(1'b0, 2'd1, "R11");
      for (int k = 1; k <= 20; k++) begin tbv = 10'(k); step("R11"); end
      for (int k = 0; k <= 60; k++) begin tbv = 10'(k); step("R11"); end
      check("R11", "stopped after late expiry", int'(wd_active), 0);

      // R9: reset while running
      tbv = '0;
      write(1'b0, 2'd0, "R9");
      for (int k = 1; k <= 7; k++) begin tbv = 10'(k); step("R9"); end
      sys_reset("R9");
      check("R9", "inactive after reset", int'(wd_active), 0);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule